// File: doc/BRIEF.md
# Audio-Driven LED Brightness Engine

This block converts a stream of digitized stereo audio into an 8-bit brightness code for a single LED channel. The left and right samples are added into one stream. A first-order digital high-pass filter then removes the DC offset, with one of two corner frequencies. A coarse attenuation made of whole-bit right shifts follows, and the block tracks the largest magnitude seen inside a refresh window. When a window closes, that peak is compared with a programmable noise floor, scaled to 8 bits and published together with a one-cycle update strobe.

The LED output port is shared with a host-programmed level. When the channel is switched off, the LED is dark. When the channel is on and audio sync is off, the host level passes through. When both the channel and sync are on, the audio-derived code drives the LED and the host level is ignored. Gain is manual only. The samples arrive already digitized, with a valid strobe.

Top module: `audio_led_sync`

## Requirements
- R1: The filter input is the sign-extended sum left + right (17 bits for 16-bit samples), taken on every cycle where `smp_vld_i` is high.
- R2: On each valid sample x the filter computes y = sat18((a * (y_prev + x - x_prev)) >>> 15), where sat18 clamps to [-131072, 131071]. The coefficient is a = 32768 - (32768*6283*fc) / (1000*FS_HZ), using integer division, with fc = 80 when `hpf_corner_i` = 0 and fc = 510 when it is 1. The filter state (y_prev, x_prev) changes only on valid samples.
- R3: Each sample's candidate is |y| shifted right by a number of bits set by `gain_sel_i`. Codes 0 to 6 shift by 0 to 6 bits, and code 7 shifts by 8 bits.
- R4: When a window closes, a window peak that is less than or equal to `thr_sel_i` * 128 yields brightness 0. Code 0 therefore only blanks a peak of 0.
- R5: Otherwise the published brightness is min(255, peak >> 7), where peak is the largest candidate in the window. The peak clears when the window closes, and the brightness holds until the next close.
- R6: With `refresh_sel_i` = 0 every sample closes a window. Codes 1, 2 and 3 close a window on every 533rd, 1052nd and 2105th sample respectively (FS_HZ*10/150, /76, /38 with FS_HZ = 8000).
- R7: The brightness and the strobe produced by a sample accepted at clock edge k appear after edge k+1. `led_upd_o` is high for exactly that one cycle.
- R8: `led_level_o` is 0 when `led_on_i` = 0. It equals `host_level_i` when `led_on_i` = 1 and `sync_en_i` = 0, and equals the audio brightness when both are 1. `led_upd_o` is driven only when both are 1.
- R9: After reset the audio brightness is 0, no strobe is pending, and the filter state and window counter are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Sample-valid strobe |
| smp_left_i | input | 16 | Left channel sample, two's complement |
| smp_right_i | input | 16 | Right channel sample, two's complement |
| hpf_corner_i | input | 1 | High-pass corner select: 0 low, 1 high |
| gain_sel_i | input | 3 | Attenuation step select |
| thr_sel_i | input | 4 | Noise floor select |
| refresh_sel_i | input | 2 | Refresh window select |
| sync_en_i | input | 1 | Audio sync enable |
| led_on_i | input | 1 | LED channel on/off |
| host_level_i | input | 8 | Host-programmed brightness |
| led_level_o | output | 8 | Brightness driven to the LED |
| led_upd_o | output | 1 | One-cycle strobe on a new audio brightness |

## Verification
A sample accepted at one edge updates the filter register at that edge. The brightness and strobe registers follow on the next edge, so results are due two edges after the sample is presented. The bench drives a sample on a falling edge, clears the valid strobe on the next falling edge, and samples the outputs on the falling edge after that. The strobe must be high at that point and low at every intermediate check inside a longer window. The on/off and sync selection is combinational, so those checks sample one falling edge after the control inputs change.

// File: rtl/audio_sync_pkg.sv
package audio_sync_pkg;

   typedef enum logic [1:0] {
      RF_EACH = 2'd0,
      RF_MID  = 2'd1,
      RF_SLOW = 2'd2,
      RF_LAZY = 2'd3
   } refresh_e;

   // whole-bit attenuation, roughly one bit per 6 dB
   function automatic int gain_shift(input logic [2:0] code);
      return (code == 3'd7) ? 8 : int'(code);
   endfunction

   // refresh rates in tenths of a hertz for the windowed settings
   function automatic int rate_tenths(input int idx);
      case (idx)
         1:       return 150;
         2:       return 76;
         default: return 38;
      endcase
   endfunction

endpackage

// File: rtl/audio_hpf.sv
module audio_hpf #(
   parameter int IN_W   = 17,
   parameter int Y_W    = 18,
   parameter int COEF_F = 15,
   parameter int FS_HZ  = 8000,
   parameter int FC_LO  = 80,
   parameter int FC_HI  = 510
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_vld,
   input  logic signed [IN_W-1:0] mix_i,
   input  logic                   corner_i,
   output logic signed [Y_W-1:0]  y_o,
   output logic                   y_vld_o
);
   localparam int CW  = COEF_F + 1;
   localparam int D_W = Y_W + 1;
   localparam int P_W = D_W + CW + 1;
   localparam longint ONE   = longint'(1) << COEF_F;
   localparam longint A_LO  = ONE - (ONE * 6283 * FC_LO) / (1000 * longint'(FS_HZ));
   localparam longint A_HI  = ONE - (ONE * 6283 * FC_HI) / (1000 * longint'(FS_HZ));

   initial begin
      assert (IN_W < Y_W) else $error("audio_hpf: Y_W must exceed IN_W");
      assert (A_HI > 0 && A_LO < ONE) else $error("audio_hpf: corner too high for FS_HZ");
   end

   logic signed [Y_W-1:0]  y_q;
   logic signed [IN_W-1:0] x_q;
   logic signed [CW:0]     coef_s;
   logic signed [D_W-1:0]  diff;
   logic signed [P_W-1:0]  prod, shifted, hi_part;
   logic signed [Y_W-1:0]  y_next;

   always_comb begin
      coef_s  = corner_i ? signed'({1'b0, CW'(A_HI)}) : signed'({1'b0, CW'(A_LO)});
      diff    = D_W'(y_q) + D_W'(mix_i) - D_W'(x_q);
      prod    = P_W'(diff) * P_W'(coef_s);
      shifted = prod >>> COEF_F;
      hi_part = shifted >>> (Y_W - 1);
      if (hi_part == '0 || hi_part == '1)
         y_next = shifted[Y_W-1:0];
      else if (shifted[P_W-1])
         y_next = {1'b1, {(Y_W-1){1'b0}}};
      else
         y_next = {1'b0, {(Y_W-1){1'b1}}};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         y_q     <= '0;
         x_q     <= '0;
         y_vld_o <= 1'b0;
      end else begin
         y_vld_o <= in_vld;
         if (in_vld) begin
            y_q <= y_next;
            x_q <= mix_i;
         end
      end
   end

   assign y_o = y_q;

   // R2: filter state moves only on accepted samples
   a_r2_hold_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
      !in_vld |=> $stable(y_q) && $stable(x_q));

endmodule

// File: rtl/audio_peak_hold.sv
module audio_peak_hold
   import audio_sync_pkg::*;
#(
   parameter int Y_W      = 18,
   parameter int BRIGHT_W = 8,
   parameter int SCALE_SH = 7,
   parameter int THR_STEP = 128,
   parameter int FS_HZ    = 8000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic signed [Y_W-1:0] y_i,
   input  logic                  y_vld_i,
   input  logic [2:0]            gain_i,
   input  logic [3:0]            thr_i,
   input  logic [1:0]            speed_i,
   output logic [BRIGHT_W-1:0]   level_o,
   output logic                  upd_o
);
   localparam int MAX_WIN = FS_HZ * 10 / 38;
   localparam int CNT_W   = $clog2(MAX_WIN + 1);
   localparam int MAX_LVL = (1 << BRIGHT_W) - 1;

   initial begin
      assert (THR_STEP * 15 < (1 << (Y_W - 1))) else $error("audio_peak_hold: THR_STEP too large");
      assert (SCALE_SH + BRIGHT_W <= Y_W) else $error("audio_peak_hold: scale out of range");
   end

   logic [CNT_W-1:0] lim_tab [4];
   assign lim_tab[0] = CNT_W'(1);
   for (genvar g = 1; g < 4; g++) begin : g_win
      localparam int WIN = FS_HZ * 10 / rate_tenths(g);
      assign lim_tab[g] = CNT_W'(WIN);
   end

   logic [Y_W-1:0]      peak_q, mag, cand, win_max, thr_lim, scaled;
   logic [CNT_W-1:0]    cnt_q, cur_lim;
   logic [BRIGHT_W-1:0] level_q, level_next;
   logic                upd_q, win_end;

   always_comb begin
      mag     = y_i[Y_W-1] ? $unsigned(-y_i) : $unsigned(y_i);
      cand    = mag >> gain_shift(gain_i);
      win_max = (cand > peak_q) ? cand : peak_q;
      thr_lim = Y_W'(thr_i) * Y_W'(THR_STEP);
      scaled  = win_max >> SCALE_SH;
      if (win_max <= thr_lim)
         level_next = '0;
      else if (scaled > Y_W'(MAX_LVL))
         level_next = '1;
      else
         level_next = scaled[BRIGHT_W-1:0];
      cur_lim = lim_tab[speed_i];
      win_end = (refresh_e'(speed_i) == RF_EACH) || (cnt_q >= cur_lim - CNT_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         peak_q  <= '0;
         cnt_q   <= '0;
         level_q <= '0;
         upd_q   <= 1'b0;
      end else begin
         upd_q <= 1'b0;
         if (y_vld_i) begin
            if (win_end) begin
               cnt_q   <= '0;
               peak_q  <= '0;
               level_q <= level_next;
               upd_q   <= 1'b1;
            end else begin
               cnt_q  <= cnt_q + CNT_W'(1);
               peak_q <= win_max;
            end
         end
      end
   end

   assign level_o = level_q;
   assign upd_o   = upd_q;

   // R7: a strobe is always the result of a filtered sample one edge earlier
   a_r7_upd_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> $past(y_vld_i));
   // R6: fastest refresh publishes on every sample
   a_r6_fast_each: assert property (@(posedge clk) disable iff (!rst_n)
      (y_vld_i && speed_i == 2'd0) |=> upd_q);
   // R5: brightness holds between window closes
   a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_q |-> $stable(level_q));
   // R5: a new window starts empty
   a_r5_peak_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      upd_q |-> (peak_q == '0 && cnt_q == '0));

endmodule

// File: rtl/audio_led_sync.sv
module audio_led_sync #(
   parameter int SAMPLE_W = 16,
   parameter int BRIGHT_W = 8,
   parameter int COEF_F   = 15,
   parameter int FS_HZ    = 8000,
   parameter int THR_STEP = 128
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                smp_vld_i,
   input  logic [SAMPLE_W-1:0] smp_left_i,
   input  logic [SAMPLE_W-1:0] smp_right_i,
   input  logic                hpf_corner_i,
   input  logic [2:0]          gain_sel_i,
   input  logic [3:0]          thr_sel_i,
   input  logic [1:0]          refresh_sel_i,
   input  logic                sync_en_i,
   input  logic                led_on_i,
   input  logic [BRIGHT_W-1:0] host_level_i,
   output logic [BRIGHT_W-1:0] led_level_o,
   output logic                led_upd_o
);
   localparam int MIX_W    = SAMPLE_W + 1;
   localparam int Y_W      = SAMPLE_W + 2;
   localparam int SCALE_SH = SAMPLE_W - BRIGHT_W - 1;

   initial begin
      assert (SAMPLE_W > BRIGHT_W) else $error("audio_led_sync: SAMPLE_W must exceed BRIGHT_W");
   end

   logic signed [MIX_W-1:0] mix;
   logic signed [Y_W-1:0]   y;
   logic                    y_vld, aud_upd;
   logic [BRIGHT_W-1:0]     aud_level;

   // R1: stereo channels summed before filtering
   assign mix = MIX_W'(signed'(smp_left_i)) + MIX_W'(signed'(smp_right_i));

   audio_hpf #(
      .IN_W(MIX_W), .Y_W(Y_W), .COEF_F(COEF_F), .FS_HZ(FS_HZ),
      .FC_LO(80), .FC_HI(510)
   ) u_hpf (
      .clk(clk), .rst_n(rst_n), .in_vld(smp_vld_i), .mix_i(mix),
      .corner_i(hpf_corner_i), .y_o(y), .y_vld_o(y_vld)
   );

   audio_peak_hold #(
      .Y_W(Y_W), .BRIGHT_W(BRIGHT_W), .SCALE_SH(SCALE_SH),
      .THR_STEP(THR_STEP), .FS_HZ(FS_HZ)
   ) u_peak (
      .clk(clk), .rst_n(rst_n), .y_i(y), .y_vld_i(y_vld),
      .gain_i(gain_sel_i), .thr_i(thr_sel_i), .speed_i(refresh_sel_i),
      .level_o(aud_level), .upd_o(aud_upd)
   );

   // R8: output selection between dark, host level and audio level
   always_comb begin
      if (!led_on_i)      led_level_o = '0;
      else if (sync_en_i) led_level_o = aud_level;
      else                led_level_o = host_level_i;
   end
   assign led_upd_o = aud_upd & sync_en_i & led_on_i;

   // R8: a dark channel never shows a strobe
   a_r8_dark_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !led_on_i |-> (led_level_o == '0 && !led_upd_o));

endmodule

// File: tb/tb_audio_led_sync.sv
module tb_audio_led_sync;
   localparam int CLK_PERIOD = 10;
   localparam int FS = 8000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vld = 1'b0;
   logic [15:0] left = '0, right = '0;
   logic        corner = 1'b0;
   logic [2:0]  gain = '0;
   logic [3:0]  thr = '0;
   logic [1:0]  speed = '0;
   logic        sync_en = 1'b1, led_on = 1'b1;
   logic [7:0]  host = '0;
   logic [7:0]  level;
   logic        upd;

   int checks = 0, fails = 0;
   bit done = 0;

   longint y_st = 0, x_st = 0, peak_m = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   audio_led_sync dut (
      .clk(clk), .rst_n(rst_n), .smp_vld_i(vld), .smp_left_i(left), .smp_right_i(right),
      .hpf_corner_i(corner), .gain_sel_i(gain), .thr_sel_i(thr), .refresh_sel_i(speed),
      .sync_en_i(sync_en), .led_on_i(led_on), .host_level_i(host),
      .led_level_o(level), .led_upd_o(upd)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint coef(input bit c);
      longint one = 32768;
      longint fc = c ? 510 : 80;
      return one - (one * 6283 * fc) / (1000 * FS);
   endfunction

   function automatic int sh_of(input int g);
      return (g == 7) ? 8 : g;
   endfunction

   function automatic int gen(input int i, input int amp);
      return ((i * 7919 + 13) % (2 * amp + 1)) - amp;
   endfunction

   function automatic longint exp_level(input longint pk, input int t);
      longint s;
      if (pk <= longint'(t) * 128) return 0;
      s = pk >> 7;
      return (s > 255) ? 255 : s;
   endfunction

   // model update for one sample (R1, R2, R3), returns candidate
   function automatic longint model(input int l, input int r);
      longint x, acc, y, mag;
      x   = longint'(l) + longint'(r);
      acc = coef(corner) * (y_st + x - x_st);
      y   = acc >>> 15;
      if (y > 131071) y = 131071;
      if (y < -131072) y = -131072;
      y_st = y; x_st = x;
      mag = (y < 0) ? -y : y;
      return mag >> sh_of(int'(gain));
   endfunction

   task automatic push(input int l, input int r);
      longint c;
      @(negedge clk);
      vld = 1'b1; left = 16'(l); right = 16'(r);
      c = model(l, r);
      if (c > peak_m) peak_m = c;
      @(negedge clk);
      vld = 1'b0;
      @(negedge clk);
   endtask

   // R6/R7: fastest refresh, check value and strobe on each sample
   task automatic push_fast(input string tag, input int l, input int r);
      longint e;
      push(l, r);
      e = exp_level(peak_m, int'(thr));
      peak_m = 0;
      chk({tag, " R7 strobe"}, longint'(upd), 1);
      chk(tag, longint'(level), e);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      chk("R9 level in reset", longint'(level), 0);
      chk("R9 strobe in reset", longint'(upd), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R9 level after reset", longint'(level), 0);
      chk("R9 strobe after reset", longint'(upd), 0);

      // R1: channel mixing patterns
      speed = 2'd0; gain = 3'd0; thr = 4'd0;
      for (int i = 0; i < 6; i++) push_fast("R1 left only", gen(i, 12000), 0);
      for (int i = 0; i < 6; i++) push_fast("R1 right only", 0, gen(i + 3, 12000));
      for (int i = 0; i < 6; i++) push_fast("R1 both", gen(i, 30000), gen(i + 7, 30000));
      push_fast("R1 opposite cancel", 20000, -20000);

      // R2/R3/R4/R5: sweep corner, gain and threshold at fastest refresh
      for (int c = 0; c < 2; c++)
         for (int g = 0; g < 8; g++)
            for (int t = 0; t < 16; t++) begin
               corner = c[0]; gain = 3'(g); thr = 4'(t);
               for (int k = 0; k < 3; k++)
                  push_fast("R2 R3 R4 R5 sweep", gen(c*1000 + g*97 + t*13 + k, 32000),
                            gen(c*500 + g*31 + t*7 + k + 2, 32000));
            end

      // R4: threshold code 0 with step into the filter
      corner = 1'b0; gain = 3'd0; thr = 4'd0;
      push_fast("R4 step", 1000, 1000);
      push_fast("R4 hold", 1000, 1000);

      // R6/R5: windowed refresh, value equals max over the window, then cleared
      for (int s = 1; s < 4; s++) begin
         int n;
         n = (s == 1) ? 533 : (s == 2) ? 1052 : 2105;
         for (int rep = 0; rep < 2; rep++) begin
            int amp;
            amp = (rep == 0) ? 20000 : 3000;
            speed = 2'(s); gain = 3'd1; thr = 4'd2; corner = 1'(s & 1);
            peak_m = 0;
            for (int i = 0; i < n; i++) begin
               push((i == n/2 && rep == 0) ? 32000 : gen(i + s, amp),
                    (i == n/2 && rep == 0) ? 32000 : gen(i + 11, amp));
               if (i < n - 1) begin
                  if (i % 128 == 0 || i == n - 2)
                     chk("R6 no strobe inside window", longint'(upd), 0);
               end
            end
            chk("R6 strobe at window close", longint'(upd), 1);
            chk("R5 window peak", longint'(level), exp_level(peak_m, int'(thr)));
            peak_m = 0;
            @(negedge clk);
            chk("R7 strobe one cycle", longint'(upd), 0);
         end
      end

      // R8: sync and enable selection
      speed = 2'd0; gain = 3'd0; thr = 4'd0; corner = 1'b0;
      push_fast("R8 audio level", 15000, 15000);
      begin
         longint aud;
         aud = longint'(level);
         host = 8'h5A; sync_en = 1'b0;
         @(negedge clk);
         chk("R8 host level with sync off", longint'(level), 8'h5A);
         push(25000, -3000);
         peak_m = 0;
         chk("R8 no strobe with sync off", longint'(upd), 0);
         chk("R8 host level still", longint'(level), 8'h5A);
         led_on = 1'b0;
         @(negedge clk);
         chk("R8 dark when off", longint'(level), 0);
         sync_en = 1'b1;
         @(negedge clk);
         chk("R8 dark when off with sync", longint'(level), 0);
         push(-8000, 4000);
         peak_m = 0;
         chk("R8 no strobe when off", longint'(upd), 0);
         led_on = 1'b1;
         push_fast("R8 audio again", 12000, 9000);
         if (aud < 0) $display("unreachable");
      end

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule